// File: doc/BRIEF.md
# Serial Command Stream Decoder

This block sits behind the clock-and-data-recovery stage of a front-end chip and turns a single serial command line, one bit per clock, into strobes for triggers, counter resets, calibration, global pulses and register accesses. The line carries an unbroken run of 16-bit frames. Each frame holds two 8-bit symbols, and each symbol has exactly four ones. A frame is therefore DC balanced by construction.

After reset the decoder hunts bit by bit for a fixed sync frame. Lock is declared only after a programmable number of sync frames have arrived back to back at 16-bit spacing. Once locked, each frame is classified as sync, trigger, command or data. A command frame repeats its command symbol in both halves. A disagreement between the halves raises an error pulse, and a single good half is still obeyed. Commands that carry arguments collect them from the data frames that follow, and they take effect only when the chip ID inside those frames matches the strapped `chip_id` pins. A programmable run of consecutive invalid frames drops lock, and the hunt begins again.

Top module: `cmd_stream_decoder`

## Requirements
- R1: Frames are sent MSB first, and the first symbol sits in bits 15:8. The valid symbols are the 70 bytes with exactly four ones, indexed 0..69 in increasing numeric order. Index 0..31 is a data symbol with value equal to the index. Index 32..46 is a trigger symbol with pattern equal to index minus 31. Index 47..53 are commands 0..6: counter-A reset (bunch), counter-B reset (event), calibration, global pulse, register write, register read, no-op. Index 54 and above, and any byte without exactly four ones, are invalid. The sync frame is 16'h817E.
- R2: `locked` is low from reset. It rises in the cycle after the last bit of the LOCK_SYNCS-th consecutive sync frame at 16-bit spacing (default 16). No output strobe occurs while unlocked.
- R3: While locked, UNLOCK_BADS (default 8) consecutive invalid frames drop `locked`. Any valid frame in between restarts that count.
- R4: A frame of a trigger symbol followed by a data symbol gives a one-cycle `trig_valid` with `trig_pattern` = 1..15 and `trig_tag` = the data value. This appears two clock cycles after the frame's last bit is sampled.
- R5: A command frame with identical halves for counter-A or counter-B reset gives a one-cycle `bcr_pulse` or `ecr_pulse` and no `frame_err`.
- R6: A frame whose halves are two different command symbols gives a one-cycle `frame_err`, executes nothing and counts as invalid.
- R7: A frame with exactly one command half is executed from that half and also gives `frame_err`.
- R8: Register write takes its argument from the next three data frames. The 30-bit payload is formed as hi,lo 5-bit values frame by frame. Chip ID is in bits 29:27, address in 26:18 and data in 17:2. A match then gives a one-cycle `wr_strobe` with `reg_addr` and `reg_wdata`.
- R9: Register read takes two data frames. In the 20-bit payload, chip ID is in bits 19:17 and address in 16:8. A match gives a one-cycle `rd_strobe` with `reg_addr`.
- R10: Calibration and global pulse each take one data frame, with chip ID in bits 9:7 and `cmd_arg` in bits 6:0. A match gives a one-cycle `cal_pulse` or `gpulse_pulse`.
- R11: When the chip ID in the payload differs from `chip_id`, an argument-carrying command produces no strobe.
- R12: A new command frame or an invalid frame abandons a pending argument collection. Sync and trigger frames in between do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low reset |
| ser_bit | input | 1 | Serial command bit, one per clock |
| chip_id | input | 3 | Strapped chip address |
| locked | output | 1 | Frame alignment established |
| trig_valid | output | 1 | Trigger frame received |
| trig_pattern | output | 4 | Trigger pattern 1..15 |
| trig_tag | output | 5 | Trigger tag value |
| bcr_pulse | output | 1 | Counter-A reset strobe |
| ecr_pulse | output | 1 | Counter-B reset strobe |
| cal_pulse | output | 1 | Calibration strobe |
| gpulse_pulse | output | 1 | Global pulse strobe |
| cmd_arg | output | 7 | Argument of the last calibration or global pulse |
| wr_strobe | output | 1 | Register write strobe |
| rd_strobe | output | 1 | Register read strobe |
| reg_addr | output | 9 | Register address |
| reg_wdata | output | 16 | Register write data |
| frame_err | output | 1 | Command halves disagreed |

## Verification
On every cycle the assertions check the following: no strobe appears unless the decoder was locked, at most one strobe fires per cycle, a trigger never carries a zero pattern, an error pulse never coincides with a data-completing strobe, and write and calibration strobes last a single cycle. Only the bench scenarios can show the symbol alphabet, the exact lock and unlock counts, payload field placement, chip-ID filtering, error correction from one good half, and which frames abandon a pending argument.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
    localparam int SYM_W      = 8;
    localparam int FRAME_W    = 2 * SYM_W;
    localparam int DSYM_W     = 5;
    localparam int FRAME_BITS = 2 * DSYM_W;
    localparam int NUM_DATA   = 32;
    localparam int NUM_TRIG   = 15;
    localparam int NUM_CMD    = 7;
    localparam int TRIG_BASE  = NUM_DATA;
    localparam int CMD_BASE   = NUM_DATA + NUM_TRIG;

    typedef enum logic [1:0] {K_DATA, K_TRIG, K_CMD, K_BAD} sym_kind_t;
    typedef enum logic [2:0] {OP_BCR, OP_ECR, OP_CAL, OP_PULSE, OP_WRREG, OP_RDREG, OP_NOP} op_t;
    typedef enum logic [1:0] {AL_HUNT, AL_ALIGN, AL_LOCK} align_st_t;

    typedef struct packed {
        sym_kind_t          kind;
        logic [DSYM_W-1:0]  val;
    } sym_info_t;

    // binomial coefficient for k <= 4
    function automatic int choose(input int n, input int k);
        case (k)
            1: return n;
            2: return n * (n - 1) / 2;
            3: return n * (n - 1) * (n - 2) / 6;
            4: return n * (n - 1) * (n - 2) * (n - 3) / 24;
            default: return 0;
        endcase
    endfunction

    // combinatorial-number-system rank of a four-ones byte
    function automatic logic [6:0] sym_rank(input logic [SYM_W-1:0] s);
        int acc;
        int ones;
        acc  = 0;
        ones = 0;
        for (int p = 0; p < SYM_W; p++) begin
            if (s[p]) begin
                ones = ones + 1;
                acc  = acc + choose(p, ones);
            end
        end
        return acc[6:0];
    endfunction
endpackage

// File: rtl/cmd_sym_classify.sv
module cmd_sym_classify
    import cmd_dec_pkg::*;
(
    input  logic [SYM_W-1:0] sym,
    output sym_info_t        info
);
    localparam logic [6:0] TRIG_B = 7'(TRIG_BASE);
    localparam logic [6:0] CMD_B  = 7'(CMD_BASE);
    localparam logic [6:0] CMD_E  = 7'(CMD_BASE + NUM_CMD);
    localparam logic [6:0] TRIG_O = 7'(TRIG_BASE - 1);

    logic [6:0] rank;
    logic [6:0] t_off;
    logic [6:0] c_off;

    always_comb begin
        rank      = sym_rank(sym);
        t_off     = rank - TRIG_O;
        c_off     = rank - CMD_B;
        info.kind = K_BAD;
        info.val  = '0;
        if ($countones(sym) == SYM_W / 2) begin
            if (rank < TRIG_B) begin
                info.kind = K_DATA;
                info.val  = rank[DSYM_W-1:0];
            end else if (rank < CMD_B) begin
                info.kind = K_TRIG;
                info.val  = t_off[DSYM_W-1:0];
            end else if (rank < CMD_E) begin
                info.kind = K_CMD;
                info.val  = c_off[DSYM_W-1:0];
            end
        end
    end
endmodule

// File: rtl/cmd_frame_align.sv
module cmd_frame_align
    import cmd_dec_pkg::*;
#(
    parameter logic [15:0] SYNC_WORD   = 16'h817E,
    parameter int          LOCK_SYNCS  = 16,
    parameter int          UNLOCK_BADS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_bit,
    input  logic               frame_bad,
    output logic               locked,
    output logic               frame_stb,
    output logic [FRAME_W-1:0] frame
);
    localparam int SC_W = $clog2(LOCK_SYNCS + 1);
    localparam int BC_W = $clog2(UNLOCK_BADS + 1);
    localparam int BT_W = $clog2(FRAME_W);
    localparam logic [BT_W-1:0] BIT_LAST = BT_W'(FRAME_W - 1);

    typedef struct packed {
        align_st_t          st;
        logic [FRAME_W-1:0] sh;
        logic [BT_W-1:0]    bitc;
        logic [SC_W-1:0]    syncs;
        logic [BC_W-1:0]    bads;
        logic               stb;
        logic [FRAME_W-1:0] frm;
    } al_t;

    al_t q, d;
    logic [FRAME_W-1:0] sh_n;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        sh_n  = {q.sh[FRAME_W-2:0], ser_bit};
        d.sh  = sh_n;
        unique case (q.st)
            AL_HUNT: begin
                if (sh_n == SYNC_WORD) begin
                    d.bitc  = '0;
                    d.syncs = SC_W'(1);
                    d.bads  = '0;
                    d.st    = (LOCK_SYNCS <= 1) ? AL_LOCK : AL_ALIGN;
                end
            end
            AL_ALIGN: begin
                d.bitc = q.bitc + 1'b1;
                if (q.bitc == BIT_LAST) begin
                    if (sh_n == SYNC_WORD) begin
                        d.syncs = q.syncs + 1'b1;
                        if (int'(q.syncs) + 1 >= LOCK_SYNCS) begin
                            d.st   = AL_LOCK;
                            d.bads = '0;
                        end
                    end else begin
                        d.st    = AL_HUNT;
                        d.syncs = '0;
                    end
                end
            end
            AL_LOCK: begin
                d.bitc = q.bitc + 1'b1;
                if (q.bitc == BIT_LAST) begin
                    d.stb = 1'b1;
                    d.frm = sh_n;
                end
                if (q.stb) begin
                    if (frame_bad) begin
                        if (int'(q.bads) + 1 >= UNLOCK_BADS) begin
                            d.st    = AL_HUNT;
                            d.syncs = '0;
                            d.bads  = '0;
                        end else begin
                            d.bads = q.bads + 1'b1;
                        end
                    end else begin
                        d.bads = '0;
                    end
                end
            end
            default: d.st = AL_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: AL_HUNT, default: '0};
        end else begin
            q <= d;
        end
    end

    assign locked    = (q.st == AL_LOCK);
    assign frame_stb = q.stb;
    assign frame     = q.frm;
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
    import cmd_dec_pkg::*;
#(
    parameter logic [15:0] SYNC_WORD   = 16'h817E,
    parameter int          LOCK_SYNCS  = 16,
    parameter int          UNLOCK_BADS = 8,
    parameter int          ID_W        = 3,
    parameter int          ADDR_W      = 9,
    parameter int          DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic [ID_W-1:0]   chip_id,
    output logic              locked,
    output logic              trig_valid,
    output logic [3:0]        trig_pattern,
    output logic [4:0]        trig_tag,
    output logic              bcr_pulse,
    output logic              ecr_pulse,
    output logic              cal_pulse,
    output logic              gpulse_pulse,
    output logic [FRAME_BITS-ID_W-1:0] cmd_arg,
    output logic              wr_strobe,
    output logic              rd_strobe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              frame_err
);
    localparam int ARG_W     = FRAME_BITS - ID_W;
    localparam int WR_FRAMES = (ID_W + ADDR_W + DATA_W + FRAME_BITS - 1) / FRAME_BITS;
    localparam int RD_FRAMES = (ID_W + ADDR_W + FRAME_BITS - 1) / FRAME_BITS;
    localparam int PAY_W     = WR_FRAMES * FRAME_BITS;
    localparam int RD_TOP    = RD_FRAMES * FRAME_BITS - 1;
    localparam int LEFT_W    = $clog2(WR_FRAMES + 1);
    localparam logic [LEFT_W-1:0] WR_LEFT  = LEFT_W'(WR_FRAMES);
    localparam logic [LEFT_W-1:0] RD_LEFT  = LEFT_W'(RD_FRAMES);
    localparam logic [LEFT_W-1:0] ONE_LEFT = LEFT_W'(1);

    typedef struct packed {
        op_t               pend;
        logic [LEFT_W-1:0] left;
        logic [PAY_W-1:0]  pay;
        logic              trig;
        logic [3:0]        tpat;
        logic [4:0]        ttag;
        logic              bcr, ecr, cal, gp, wr, rd, err;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [ARG_W-1:0]  arg;
    } dec_t;

    dec_t q, d;

    logic               frame_stb;
    logic               frame_bad;
    logic [FRAME_W-1:0] frame;
    sym_info_t          info [2];
    logic [PAY_W-1:0]   pay_n;
    op_t                op;
    logic               hi_cmd, lo_cmd;

    cmd_frame_align #(
        .SYNC_WORD  (SYNC_WORD),
        .LOCK_SYNCS (LOCK_SYNCS),
        .UNLOCK_BADS(UNLOCK_BADS)
    ) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_bit  (ser_bit),
        .frame_bad(frame_bad),
        .locked   (locked),
        .frame_stb(frame_stb),
        .frame    (frame)
    );

    // info[1] is the first (upper) symbol, info[0] the second
    for (genvar g = 0; g < 2; g++) begin : g_sym
        cmd_sym_classify u_cls (
            .sym (frame[g*SYM_W +: SYM_W]),
            .info(info[g])
        );
    end

    always_comb begin
        d       = q;
        d.trig  = 1'b0;
        d.bcr   = 1'b0;
        d.ecr   = 1'b0;
        d.cal   = 1'b0;
        d.gp    = 1'b0;
        d.wr    = 1'b0;
        d.rd    = 1'b0;
        d.err   = 1'b0;
        frame_bad = 1'b0;
        hi_cmd  = (info[1].kind == K_CMD);
        lo_cmd  = (info[0].kind == K_CMD);
        op      = op_t'(hi_cmd ? info[1].val[2:0] : info[0].val[2:0]);
        pay_n   = {q.pay[PAY_W-FRAME_BITS-1:0], info[1].val, info[0].val};
        if (!locked) begin
            d.left = '0;
        end else if (frame_stb) begin
            if (frame == SYNC_WORD) begin
                d.left = q.left;
            end else if (hi_cmd || lo_cmd) begin
                if (hi_cmd && lo_cmd && (info[1].val != info[0].val)) begin
                    d.err     = 1'b1;
                    frame_bad = 1'b1;
                    d.left    = '0;
                end else begin
                    d.err  = !(hi_cmd && lo_cmd);
                    d.left = '0;
                    d.pend = op;
                    unique case (op)
                        OP_BCR:           d.bcr  = 1'b1;
                        OP_ECR:           d.ecr  = 1'b1;
                        OP_CAL, OP_PULSE: d.left = ONE_LEFT;
                        OP_WRREG:         d.left = WR_LEFT;
                        OP_RDREG:         d.left = RD_LEFT;
                        default:          d.left = '0;
                    endcase
                end
            end else if (info[1].kind == K_TRIG && info[0].kind == K_DATA) begin
                d.trig = 1'b1;
                d.tpat = info[1].val[3:0];
                d.ttag = info[0].val;
            end else if (info[1].kind == K_DATA && info[0].kind == K_DATA) begin
                if (q.left != '0) begin
                    d.pay  = pay_n;
                    d.left = q.left - 1'b1;
                    if (q.left == ONE_LEFT) begin
                        unique case (q.pend)
                            OP_WRREG: if (pay_n[PAY_W-1 -: ID_W] == chip_id) begin
                                d.wr    = 1'b1;
                                d.addr  = pay_n[PAY_W-1-ID_W -: ADDR_W];
                                d.wdata = pay_n[PAY_W-1-ID_W-ADDR_W -: DATA_W];
                            end
                            OP_RDREG: if (pay_n[RD_TOP -: ID_W] == chip_id) begin
                                d.rd   = 1'b1;
                                d.addr = pay_n[RD_TOP-ID_W -: ADDR_W];
                            end
                            OP_CAL, OP_PULSE: if (pay_n[FRAME_BITS-1 -: ID_W] == chip_id) begin
                                d.cal = (q.pend == OP_CAL);
                                d.gp  = (q.pend == OP_PULSE);
                                d.arg = pay_n[ARG_W-1:0];
                            end
                            default: d.left = '0;
                        endcase
                    end
                end
            end else begin
                frame_bad = 1'b1;
                d.left    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{pend: OP_NOP, default: '0};
        end else begin
            q <= d;
        end
    end

    assign trig_valid   = q.trig;
    assign trig_pattern = q.tpat;
    assign trig_tag     = q.ttag;
    assign bcr_pulse    = q.bcr;
    assign ecr_pulse    = q.ecr;
    assign cal_pulse    = q.cal;
    assign gpulse_pulse = q.gp;
    assign cmd_arg      = q.arg;
    assign wr_strobe    = q.wr;
    assign rd_strobe    = q.rd;
    assign reg_addr     = q.addr;
    assign reg_wdata    = q.wdata;
    assign frame_err    = q.err;
endmodule

// File: rtl/cmd_stream_decoder_chk.sv
module cmd_stream_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       locked,
    input logic       trig_valid,
    input logic [3:0] trig_pattern,
    input logic       bcr_pulse,
    input logic       ecr_pulse,
    input logic       cal_pulse,
    input logic       gpulse_pulse,
    input logic       wr_strobe,
    input logic       rd_strobe,
    input logic       frame_err
);
    logic any_out;
    assign any_out = trig_valid | bcr_pulse | ecr_pulse | cal_pulse | gpulse_pulse
                   | wr_strobe | rd_strobe | frame_err;

    assert_strobe_needs_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any_out |-> $past(locked));

    assert_trig_pattern_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> (trig_pattern != 4'd0));

    assert_single_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trig_valid, bcr_pulse, ecr_pulse, cal_pulse, gpulse_pulse, wr_strobe, rd_strobe}));

    assert_err_not_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !(wr_strobe | rd_strobe | trig_valid));

    assert_wr_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    assert_cal_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cal_pulse |=> !cal_pulse);
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk u_chk (.*);

// File: tb/cmd_stream_decoder_test.sv
module cmd_stream_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] SYNC = 16'h817E;
    localparam logic [2:0] MY_ID = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_bit = 1'b0;
    logic [2:0] chip_id = MY_ID;
    logic locked, trig_valid, bcr_pulse, ecr_pulse, cal_pulse, gpulse_pulse;
    logic wr_strobe, rd_strobe, frame_err;
    logic [3:0] trig_pattern;
    logic [4:0] trig_tag;
    logic [6:0] cmd_arg;
    logic [8:0] reg_addr;
    logic [15:0] reg_wdata;

    int n_chk = 0, n_bad = 0;
    int c_trig = 0, c_bcr = 0, c_ecr = 0, c_cal = 0, c_gp = 0, c_wr = 0, c_rd = 0, c_err = 0;
    bit done = 0;
    logic [7:0] bal [70];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_stream_decoder uut (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .chip_id(chip_id),
        .locked(locked), .trig_valid(trig_valid), .trig_pattern(trig_pattern),
        .trig_tag(trig_tag), .bcr_pulse(bcr_pulse), .ecr_pulse(ecr_pulse),
        .cal_pulse(cal_pulse), .gpulse_pulse(gpulse_pulse), .cmd_arg(cmd_arg),
        .wr_strobe(wr_strobe), .rd_strobe(rd_strobe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .frame_err(frame_err)
    );

    // pulse counters sampled away from the active edge
    always @(negedge clk) begin
        if (trig_valid)   c_trig++;
        if (bcr_pulse)    c_bcr++;
        if (ecr_pulse)    c_ecr++;
        if (cal_pulse)    c_cal++;
        if (gpulse_pulse) c_gp++;
        if (wr_strobe)    c_wr++;
        if (rd_strobe)    c_rd++;
        if (frame_err)    c_err++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] dfr(input logic [9:0] v);
        return {bal[v[9:5]], bal[v[4:0]]};
    endfunction
    function automatic logic [15:0] cfr(input int op);
        return {bal[47+op], bal[47+op]};
    endfunction
    function automatic logic [15:0] tfr(input int pat, input int tag);
        return {bal[31+pat], bal[tag]};
    endfunction

    task automatic send_bits(input logic [15:0] f, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            @(negedge clk);
            ser_bit = f[i];
        end
    endtask
    task automatic send_frame(input logic [15:0] f);
        send_bits(f, 15, 0);
    endtask
    task automatic idle();
        send_frame(cfr(6));
    endtask

    task automatic t_reset();
        check("R2 reset locked", locked, 0);
        check("R4 reset trig", trig_valid, 0);
        check("R8 reset wr", wr_strobe, 0);
    endtask

    task automatic t_lock();
        for (int i = 0; i < 40; i++) send_bits(16'h0000, 0, 0);
        for (int i = 0; i < 15; i++) send_frame(SYNC);
        send_bits(SYNC, 15, 15);
        check("R2 not locked after 15 syncs", locked, 0);
        send_bits(SYNC, 14, 0);
        send_bits(cfr(6), 15, 15);
        check("R2 locked after 16 syncs", locked, 1);
        send_bits(cfr(6), 14, 0);
        idle();
    endtask

    task automatic t_trigger();
        int t0 = c_trig;
        send_frame(tfr(9, 21));
        send_bits(cfr(6), 15, 15);
        check("R4 trig not yet", trig_valid, 0);
        send_bits(cfr(6), 14, 14);
        check("R4 trig latency", trig_valid, 1);
        check("R4 trig pattern", trig_pattern, 9);
        check("R4 trig tag", trig_tag, 21);
        send_bits(cfr(6), 13, 0);
        check("R4 trig count", c_trig - t0, 1);
        send_frame(tfr(15, 0));
        idle();
        check("R1 trig pattern 15", trig_pattern, 15);
    endtask

    task automatic t_fast_cmds();
        int b0 = c_bcr, e0 = c_ecr, r0 = c_err;
        send_frame(cfr(0));
        send_frame(cfr(1));
        idle();
        check("R5 bcr count", c_bcr - b0, 1);
        check("R5 ecr count", c_ecr - e0, 1);
        check("R5 no err", c_err - r0, 0);
    endtask

    task automatic t_mismatch();
        int b0 = c_bcr, e0 = c_ecr, r0 = c_err;
        send_frame({bal[47], bal[48]});
        idle();
        check("R6 err pulse", c_err - r0, 1);
        check("R6 nothing executed", (c_bcr - b0) + (c_ecr - e0), 0);
    endtask

    task automatic t_correct();
        int b0 = c_bcr, e0 = c_ecr, r0 = c_err;
        send_frame({bal[47], 8'hFF});
        send_frame({8'h00, bal[48]});
        idle();
        check("R7 bcr from upper half", c_bcr - b0, 1);
        check("R7 ecr from lower half", c_ecr - e0, 1);
        check("R7 err pulses", c_err - r0, 2);
    endtask

    task automatic do_write(input logic [2:0] id, input logic [8:0] a, input logic [15:0] v);
        logic [29:0] p = {id, a, v, 2'b00};
        send_frame(cfr(4));
        send_frame(dfr(p[29:20]));
        send_frame(dfr(p[19:10]));
        send_frame(dfr(p[9:0]));
        idle();
    endtask

    task automatic t_write();
        int w0 = c_wr;
        do_write(MY_ID, 9'h1A5, 16'hBEEF);
        check("R8 wr count", c_wr - w0, 1);
        check("R8 wr addr", reg_addr, 9'h1A5);
        check("R8 wr data", reg_wdata, 16'hBEEF);
        do_write(MY_ID, 9'h003, 16'h8001);
        check("R8 wr data 2", reg_wdata, 16'h8001);
        check("R1 wr addr 2", reg_addr, 9'h003);
    endtask

    task automatic t_read();
        int r0 = c_rd;
        logic [19:0] p = {MY_ID, 9'h0F0, 8'h00};
        send_frame(cfr(5));
        send_frame(dfr(p[19:10]));
        send_frame(dfr(p[9:0]));
        idle();
        check("R9 rd count", c_rd - r0, 1);
        check("R9 rd addr", reg_addr, 9'h0F0);
    endtask

    task automatic t_cal_pulse();
        int c0 = c_cal, g0 = c_gp;
        send_frame(cfr(2));
        send_frame(dfr({MY_ID, 7'h5A}));
        idle();
        check("R10 cal count", c_cal - c0, 1);
        check("R10 cal arg", cmd_arg, 7'h5A);
        send_frame(cfr(3));
        send_frame(dfr({MY_ID, 7'h11}));
        idle();
        check("R10 gpulse count", c_gp - g0, 1);
        check("R10 gpulse arg", cmd_arg, 7'h11);
    endtask

    task automatic t_foreign_id();
        int w0 = c_wr, c0 = c_cal;
        do_write(3'd2, 9'h044, 16'h1234);
        check("R11 no wr for other id", c_wr - w0, 0);
        check("R11 wdata kept", reg_wdata, 16'h8001);
        send_frame(cfr(2));
        send_frame(dfr({3'd4, 7'h22}));
        idle();
        check("R11 no cal for other id", c_cal - c0, 0);
    endtask

    task automatic t_abort();
        int w0 = c_wr, r0 = c_rd;
        logic [29:0] pw = {MY_ID, 9'h111, 16'h2222, 2'b00};
        logic [19:0] pr = {MY_ID, 9'h077, 8'h00};
        send_frame(cfr(4));
        send_frame(dfr(pw[29:20]));
        send_frame(cfr(5));
        send_frame(dfr(pr[19:10]));
        send_frame(tfr(3, 4));
        send_frame(SYNC);
        send_frame(dfr(pr[9:0]));
        send_frame(dfr(pw[9:0]));
        idle();
        check("R12 write abandoned", c_wr - w0, 0);
        check("R12 read survives sync and trigger", c_rd - r0, 1);
        check("R12 read addr", reg_addr, 9'h077);
        send_frame(cfr(5));
        send_frame(dfr(pr[19:10]));
        send_frame(16'h0000);
        send_frame(dfr(pr[9:0]));
        idle();
        check("R12 invalid frame abandons", c_rd - r0, 1);
    endtask

    task automatic t_unlock();
        for (int i = 0; i < 7; i++) send_frame(16'h0000);
        send_frame(tfr(1, 1));
        for (int i = 0; i < 7; i++) send_frame(16'hFFFF);
        send_bits(cfr(6), 15, 15);
        check("R3 valid frame restarts count", locked, 1);
        send_bits(cfr(6), 14, 0);
        for (int i = 0; i < 8; i++) send_frame(16'h0000);
        send_bits(16'h0000, 1, 0);
        check("R3 lock dropped", locked, 0);
        for (int i = 0; i < 16; i++) send_frame(SYNC);
        idle();
        check("R2 relocked", locked, 1);
    endtask

    initial begin
        int k = 0;
        for (int v = 0; v < 256; v++) begin
            if ($countones(v[7:0]) == 4) begin
                bal[k] = v[7:0];
                k++;
            end
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_lock();
        t_trigger();
        t_fast_cmds();
        t_mismatch();
        t_correct();
        t_write();
        t_read();
        t_cal_pulse();
        t_foreign_id();
        t_abort();
        t_unlock();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule